// File: doc/BRIEF.md
# Interrupt Priority Resolver

This block chooses the single interrupt to take at each instruction boundary. It watches two kinds of source. The first is eight non-maskable special sources, whose ranking is fixed in hardware. The second is a vector of maskable peripheral sources, each with its own 3-bit programmed level. A one-cycle pulse on any request line is latched as pending. When the boundary strobe is high, the block picks the best eligible pending source. It registers that choice as a one-cycle grant and clears the pending bit of the chosen source.

A maskable source can only compete if the global enable is set and its level is strictly above the current processor level. Among eligible maskable sources, the higher level wins; on equal levels, the lower index wins. Special sources ignore the enable, the processor level and every programmed level. Six of them outrank all maskable sources. Single step and address match rank below the maskable group. A software request line does not take part in arbitration and is passed straight through.

Top module: `irq_priority_resolver`

## Requirements
- R1: While `rstN` is low and after its release, `grantValid` is 0, `grantIdx` and `grantLevel` are 0, and no source is pending.
- R2: A one-cycle pulse on a `specialReq` or `periphReq` bit stays pending across any number of cycles without a boundary strobe, until that source is granted.
- R3: `grantValid` is 1 only in the cycle after a cycle in which `boundary` was 1 and an eligible pending source existed. `grantIdx` and `grantLevel` keep their values until the next grant.
- R4: Special bits 0 to 5 outrank every maskable source, with the lower bit winning: 0 reset, 1 watchdog, 2 oscillation stop, 3 voltage monitor 2, 4 voltage monitor 1, 5 address break.
- R5: Peripheral k is eligible only when `intEnable` is 1 and its level (`periphLevel[3k+2:3k]`) is strictly greater than `cpuLevel`, so level 0 never wins.
- R6: Among eligible peripherals, the highest level wins; on equal levels, the lowest index wins.
- R7: Special bit 6 (single step) and then bit 7 (address match) win only when no higher special and no eligible peripheral is pending. Neither is gated by `intEnable` or `cpuLevel`.
- R8: A pending reset request (special bit 0) is granted over any other request, whatever the values of `intEnable` and `cpuLevel`.
- R9: At the granting edge, only the winner's pending bit is cleared. Every other pending source is still pending and is granted at a later boundary.
- R10: `swReqOut` follows `swReqIn` combinationally, with no arbitration.
- R11: `grantIdx` is i for special bit i and 8+k for peripheral k. `grantLevel` is the programmed level for a peripheral grant and 0 for a special grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| specialReq | input | 8 | Special request pulses, bit order per R4 and R7 |
| periphReq | input | NUM_PERIPH | Maskable peripheral request pulses |
| periphLevel | input | NUM_PERIPH*LVL_W | Programmed level per peripheral, LVL_W bits each |
| intEnable | input | 1 | Global maskable-interrupt enable |
| cpuLevel | input | LVL_W | Current processor priority level |
| boundary | input | 1 | Instruction-boundary strobe |
| swReqIn | input | 1 | Software interrupt request |
| grantValid | output | 1 | One-cycle grant strobe |
| grantIdx | output | IDX_W | Winning source index per R11 |
| grantLevel | output | LVL_W | Winning level per R11 |
| swReqOut | output | 1 | Software request, passed through |

## Verification
Two things can happen at the same edge: a grant that clears one pending bit, and the arrival of a new request on another line, or on the same line. The sequences latch several requests at once, mixing special and maskable sources with equal and differing levels. The bench then steps through boundary strobes one at a time and checks that each grant follows the ranking. It also checks that every source left unserved is still granted later, in order. Randomised request and level patterns are compared against an independent reference model of the ranking rules.

// File: rtl/prio_pkg.sv
package prio_pkg;
  localparam int SPECIAL_COUNT = 8;
  localparam int SP_RESET      = 0;
  localparam int SP_HIGH_LAST  = 5;  // bits 0..5 outrank maskable sources
  localparam int SP_SSTEP      = 6;
  localparam int SP_AMATCH     = 7;

  typedef struct packed {
    logic loadGrant;   // register the current winner
    logic clearPend;   // drop the winner's pending bit
  } prioStrobe_t;
endpackage

// File: rtl/prio_control.sv
module prio_control
  import prio_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        boundary,
  input  logic        winValid,
  output prioStrobe_t strobe,
  output logic        grantValid
);
  logic takeNow;

  always_comb begin
    takeNow          = boundary & winValid;
    strobe.loadGrant = takeNow;
    strobe.clearPend = takeNow;
  end

  always_ff @(posedge clk) begin
    if (!rstN) grantValid <= 1'b0;
    else       grantValid <= takeNow;
  end

  AST_GRANT_AFTER_BOUNDARY: assert property (@(posedge clk) disable iff (!rstN)
    grantValid |-> $past(boundary)); // R3
endmodule

// File: rtl/prio_datapath.sv
module prio_datapath
  import prio_pkg::*;
#(
  parameter int NUM_PERIPH = 16,
  parameter int LVL_W      = 3,
  parameter int IDX_W      = $clog2(SPECIAL_COUNT + NUM_PERIPH)
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [SPECIAL_COUNT-1:0]    specialReq,
  input  logic [NUM_PERIPH-1:0]       periphReq,
  input  logic [NUM_PERIPH*LVL_W-1:0] periphLevel,
  input  logic                        intEnable,
  input  logic [LVL_W-1:0]            cpuLevel,
  input  prioStrobe_t                 strobe,
  output logic                        winValid,
  output logic [IDX_W-1:0]            grantIdx,
  output logic [LVL_W-1:0]            grantLevel
);
  localparam int TOTAL = SPECIAL_COUNT + NUM_PERIPH;

  logic [TOTAL-1:0]      pendAll;
  logic [TOTAL-1:0]      reqAll;
  logic [TOTAL-1:0]      winMask;
  logic [NUM_PERIPH-1:0] eligible;
  logic [LVL_W-1:0]      lvlOf [NUM_PERIPH];
  logic [IDX_W-1:0]      winIdx;
  logic [LVL_W-1:0]      winLevel;

  logic                  bestFound;
  logic [IDX_W-1:0]      bestIdx;
  logic [LVL_W-1:0]      bestLvl;
  logic                  highFound;
  logic [IDX_W-1:0]      highIdx;

  assign reqAll = {periphReq, specialReq};

  // per-source eligibility
  for (genvar k = 0; k < NUM_PERIPH; k++) begin : g_elig
    assign lvlOf[k]    = periphLevel[k*LVL_W +: LVL_W];
    assign eligible[k] = pendAll[SPECIAL_COUNT+k] & intEnable & (lvlOf[k] > cpuLevel);
  end

  // maskable group: highest level, lowest index on ties
  always_comb begin
    bestFound = 1'b0;
    bestIdx   = '0;
    bestLvl   = '0;
    for (int k = 0; k < NUM_PERIPH; k++) begin
      if (eligible[k] && (!bestFound || lvlOf[k] > bestLvl)) begin
        bestFound = 1'b1;
        bestIdx   = IDX_W'(SPECIAL_COUNT + k);
        bestLvl   = lvlOf[k];
      end
    end
  end

  // upper special group: lowest bit wins
  always_comb begin
    highFound = 1'b0;
    highIdx   = '0;
    for (int i = SP_HIGH_LAST; i >= 0; i--) begin
      if (pendAll[i]) begin
        highFound = 1'b1;
        highIdx   = IDX_W'(i);
      end
    end
  end

  // final ranking across the three groups
  always_comb begin
    winValid = 1'b1;
    winIdx   = '0;
    winLevel = '0;
    if (highFound) begin
      winIdx = highIdx;
    end else if (bestFound) begin
      winIdx   = bestIdx;
      winLevel = bestLvl;
    end else if (pendAll[SP_SSTEP]) begin
      winIdx = IDX_W'(SP_SSTEP);
    end else if (pendAll[SP_AMATCH]) begin
      winIdx = IDX_W'(SP_AMATCH);
    end else begin
      winValid = 1'b0;
    end
  end

  always_comb begin
    winMask = '0;
    if (strobe.clearPend) winMask[winIdx] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) pendAll <= '0;
    else       pendAll <= (pendAll & ~winMask) | reqAll;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      grantIdx   <= '0;
      grantLevel <= '0;
    end else if (strobe.loadGrant) begin
      grantIdx   <= winIdx;
      grantLevel <= winLevel;
    end
  end

  AST_RESET_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.loadGrant && pendAll[SP_RESET]) |=> (grantIdx == IDX_W'(SP_RESET))); // R8

  AST_PEND_CLEARED: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.clearPend && !reqAll[winIdx]) |=> !pendAll[$past(winIdx)]); // R9

  AST_MASKABLE_ABOVE_CPU: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.loadGrant && winIdx >= IDX_W'(SPECIAL_COUNT))
      |=> ((grantLevel > $past(cpuLevel)) && $past(intEnable))); // R5

  AST_LOAD_NEEDS_WINNER: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadGrant |-> (pendAll != '0)); // R3
endmodule

// File: rtl/irq_priority_resolver.sv
module irq_priority_resolver
  import prio_pkg::*;
#(
  parameter int NUM_PERIPH = 16,
  parameter int LVL_W      = 3,
  localparam int IDX_W     = $clog2(SPECIAL_COUNT + NUM_PERIPH)
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [SPECIAL_COUNT-1:0]    specialReq,
  input  logic [NUM_PERIPH-1:0]       periphReq,
  input  logic [NUM_PERIPH*LVL_W-1:0] periphLevel,
  input  logic                        intEnable,
  input  logic [LVL_W-1:0]            cpuLevel,
  input  logic                        boundary,
  input  logic                        swReqIn,
  output logic                        grantValid,
  output logic [IDX_W-1:0]            grantIdx,
  output logic [LVL_W-1:0]            grantLevel,
  output logic                        swReqOut
);
  prioStrobe_t strobe;
  logic        winValid;

  assign swReqOut = swReqIn;  // software requests skip arbitration

  prio_control u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .boundary  (boundary),
    .winValid  (winValid),
    .strobe    (strobe),
    .grantValid(grantValid)
  );

  prio_datapath #(
    .NUM_PERIPH(NUM_PERIPH),
    .LVL_W     (LVL_W),
    .IDX_W     (IDX_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .specialReq (specialReq),
    .periphReq  (periphReq),
    .periphLevel(periphLevel),
    .intEnable  (intEnable),
    .cpuLevel   (cpuLevel),
    .strobe     (strobe),
    .winValid   (winValid),
    .grantIdx   (grantIdx),
    .grantLevel (grantLevel)
  );
endmodule

// File: tb/irq_priority_resolver_test.sv
module irq_priority_resolver_test;
  localparam int N = 16;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [7:0]    specialReq = '0;
  logic [N-1:0]  periphReq = '0;
  logic [3*N-1:0] periphLevel = '0;
  logic          intEnable = 1'b0;
  logic [2:0]    cpuLevel = '0;
  logic          boundary = 1'b0;
  logic          swReqIn = 1'b0;
  logic          grantValid;
  logic [4:0]    grantIdx;
  logic [2:0]    grantLevel;
  logic          swReqOut;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  irq_priority_resolver #(.NUM_PERIPH(N), .LVL_W(3)) uut (
    .clk(clk), .rstN(rstN), .specialReq(specialReq), .periphReq(periphReq),
    .periphLevel(periphLevel), .intEnable(intEnable), .cpuLevel(cpuLevel),
    .boundary(boundary), .swReqIn(swReqIn), .grantValid(grantValid),
    .grantIdx(grantIdx), .grantLevel(grantLevel), .swReqOut(swReqOut)
  );

  typedef struct packed {
    logic [7:0]  sp;
    logic [15:0] pr;
    logic [47:0] lv;
    logic        en;
    logic [2:0]  cpu;
    logic        v;
    logic [4:0]  idx;
    logic [2:0]  lvl;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{8'h00, 16'h0008, 48'h000000000A00, 1'b1, 3'd0, 1'b1, 5'd11, 3'd5}, // R5 R11
    '{8'h00, 16'h0044, 48'h000000100100, 1'b1, 3'd0, 1'b1, 5'd10, 3'd4}, // R6 tie
    '{8'h00, 16'h0202, 48'h000030000018, 1'b1, 3'd0, 1'b1, 5'd17, 3'd6}, // R6 level
    '{8'h00, 16'hFFFF, 48'h000000000000, 1'b1, 3'd0, 1'b0, 5'd0,  3'd0}, // R5 zeros
    '{8'h00, 16'h0010, 48'h000000002000, 1'b1, 3'd2, 1'b0, 5'd0,  3'd0}, // R5 equal cpu
    '{8'h00, 16'h0010, 48'h000000002000, 1'b1, 3'd1, 1'b1, 5'd12, 3'd2}, // R5 above
    '{8'h00, 16'h0001, 48'h000000000007, 1'b0, 3'd0, 1'b0, 5'd0,  3'd0}, // R5 disabled
    '{8'h02, 16'h0001, 48'h000000000007, 1'b1, 3'd0, 1'b1, 5'd1,  3'd0}, // R4
    '{8'h40, 16'h0001, 48'h000000000007, 1'b1, 3'd0, 1'b1, 5'd8,  3'd7}, // R7
    '{8'hC0, 16'h0000, 48'h000000000000, 1'b0, 3'd7, 1'b1, 5'd6,  3'd0}, // R7
    '{8'h03, 16'h0000, 48'h000000000000, 1'b0, 3'd7, 1'b1, 5'd0,  3'd0}, // R8
    '{8'h0C, 16'h0001, 48'h000000000007, 1'b1, 3'd0, 1'b1, 5'd2,  3'd0}  // R4
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [8:0] refPick(input logic [7:0] sp, input logic [15:0] pr,
      input logic [47:0] lv, input logic en, input logic [2:0] cpu);
    int best = -1;
    logic [2:0] bl = '0;
    for (int i = 0; i < 6; i++) if (sp[i]) return {1'b1, 5'(i), 3'd0};
    for (int k = 0; k < 16; k++)
      if (pr[k] && en && lv[3*k +: 3] > cpu && (best < 0 || lv[3*k +: 3] > bl)) begin
        best = k;
        bl = lv[3*k +: 3];
      end
    if (best >= 0) return {1'b1, 5'(8 + best), bl};
    if (sp[6]) return {1'b1, 5'd6, 3'd0};
    if (sp[7]) return {1'b1, 5'd7, 3'd0};
    return 9'd0;
  endfunction

  task automatic doReset();
    rstN = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic pulseReq(input logic [7:0] sp, input logic [15:0] pr);
    specialReq = sp; periphReq = pr;
    @(negedge clk);
    specialReq = '0; periphReq = '0;
  endtask

  task automatic strobeOnce();
    boundary = 1'b1;
    @(negedge clk);
    boundary = 1'b0;
  endtask

  task automatic runCase(input string req, input logic [7:0] sp, input logic [15:0] pr,
      input logic [47:0] lv, input logic en, input logic [2:0] cpu, input logic [8:0] exp);
    doReset();
    periphLevel = lv; intEnable = en; cpuLevel = cpu;
    pulseReq(sp, pr);
    strobeOnce();
    chk(req, {grantValid, grantIdx, grantLevel}, exp);
  endtask

  initial begin
    #1500000;
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    @(negedge clk);
    chk("R1 valid in reset", grantValid, 0);
    chk("R1 idx/level in reset", {grantIdx, grantLevel}, 0);
    rstN = 1'b1;
    intEnable = 1'b1;
    strobeOnce();
    chk("R1 nothing pending", grantValid, 0);

    // table walk
    for (int v = 0; v < NV; v++)
      runCase("R4-R8 table vector", VECS[v].sp, VECS[v].pr, VECS[v].lv, VECS[v].en,
              VECS[v].cpu, {VECS[v].v, VECS[v].idx, VECS[v].lvl});

    // R2 pending held across cycles without boundary
    doReset();
    periphLevel = 48'h40; intEnable = 1'b1; cpuLevel = 3'd0; // periph 2 level 1
    pulseReq(8'h00, 16'h0004);
    for (int c = 0; c < 5; c++) begin
      @(negedge clk);
      chk("R2 no grant without boundary", grantValid, 0);
    end
    strobeOnce();
    chk("R2 held request granted", {grantValid, grantIdx, grantLevel}, {1'b1, 5'd10, 3'd1});

    // R9 / R3 drain order: periph0 level 3, periph5 level 6
    doReset();
    periphLevel = 48'h0; periphLevel[2:0] = 3'd3; periphLevel[17:15] = 3'd6;
    pulseReq(8'h00, 16'h0021);
    strobeOnce();
    chk("R9 first grant", {grantValid, grantIdx, grantLevel}, {1'b1, 5'd13, 3'd6});
    @(negedge clk);
    chk("R3 grant one cycle", grantValid, 0);
    chk("R3 outputs held", {grantIdx, grantLevel}, {5'd13, 3'd6});
    strobeOnce();
    chk("R9 second grant", {grantValid, grantIdx, grantLevel}, {1'b1, 5'd8, 3'd3});
    strobeOnce();
    chk("R9 drained", grantValid, 0);

    // R9 new request arriving on the edge that clears another
    doReset();
    periphLevel = 48'h0; periphLevel[2:0] = 3'd3;
    pulseReq(8'h02, 16'h0000);
    boundary = 1'b1; periphReq = 16'h0001;
    @(negedge clk);
    boundary = 1'b0; periphReq = '0;
    chk("R9 special first", {grantValid, grantIdx}, {1'b1, 5'd1});
    strobeOnce();
    chk("R9 coincident request kept", {grantValid, grantIdx, grantLevel}, {1'b1, 5'd8, 3'd3});

    // R10 software pass-through
    swReqIn = 1'b1; #1;
    chk("R10 sw high", swReqOut, 1);
    swReqIn = 1'b0; #1;
    chk("R10 sw low", swReqOut, 0);

    // random patterns against reference model (R4 R5 R6 R7 R8 R11)
    for (int r = 0; r < 300; r++) begin
      logic [7:0] sp;
      logic [15:0] pr;
      logic [47:0] lv;
      logic en;
      logic [2:0] cpu;
      sp  = ($urandom % 3 == 0) ? 8'($urandom) : 8'h00;
      pr  = 16'($urandom);
      lv  = {16'($urandom), 32'($urandom)};
      en  = 1'($urandom);
      cpu = 3'($urandom);
      runCase("R6 random vs model", sp, pr, lv, en, cpu, refPick(sp, pr, lv, en, cpu));
    end

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule